// File: doc/BRIEF.md
# Quad-Input Page Program Receiver

This block is the device-side receiver for one page-program command of a serial flash. While the chip-select line is low, it shifts in an 8-bit command code on SIO0, one bit per serial clock. If the code matches, it takes a 24-bit address and then data bytes as 4-bit groups on SIO[3:0], one group per serial clock. The data bytes go into a page staging buffer. Successive bytes step through the low eight address bits and wrap inside the 256-byte page, while the upper address bits stay fixed.

The command is committed when chip-select rises, but only if three conditions hold at that moment. The external write-enable latch must be set, at least one whole byte must have arrived, and no half byte may be pending. On commit, the block issues a one-cycle program request that carries the start address and a per-byte strobe mask. It then holds a busy flag for a fixed number of system clocks. When the busy time ends, each strobed byte is merged into a register-held memory model with program-to-zero semantics (old AND new), and a one-cycle pulse asks the outside to clear the write-enable latch. A read port exposes the memory model.

The serial pins are sampled on the system clock. Serial clock edges and chip-select edges are found by comparing each registered sample with the one before it.

Top module: `qpp_rx`

## Requirements
- R1: After reset, busy, prog_req and wel_clr are 0, and every memory byte reads 8'hFF.
- R2: The command code is taken MSB first from SIO0 on eight serial clock rising edges. Only the code OPCODE (default 8'h38) starts a program; any other code leaves the memory unchanged and raises no request.
- R3: After the code, six 4-bit groups on SIO[3:0] form the 24-bit address, most significant group first. Each following data byte is two groups, high group first. The first byte is written at the address given.
- R4: A program stores old AND new in each strobed byte, so bits can only go from 1 to 0.
- R5: Successive data bytes increment address bits [7:0] modulo 256 and keep the upper bits. A byte after offset 8'hFF lands at offset 8'h00 of the same page.
- R6: If wel is 0 when chip-select rises, the frame is discarded: no request, no wel_clr pulse, and the memory is unchanged.
- R7: A frame that ends with no complete data byte, or with a half byte pending, is discarded.
- R8: A commit raises prog_req for exactly one cycle. prog_addr then equals the received address, and prog_strb has one bit set for each page offset written in that frame.
- R9: busy rises the cycle after prog_req and stays high for exactly PROG_CYCLES cycles. The memory update and a single-cycle wel_clr pulse occur on the cycle busy falls.
- R10: A frame whose chip-select falls while busy is 1 is ignored entirely.
- R11: When one frame writes the same page offset more than once, the last byte written to that offset is the one programmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock, sampled on clk |
| sio | input | 4 | Serial data lines; SIO0 carries the command code |
| wel | input | 1 | Write-enable latch state |
| wel_clr | output | 1 | One-cycle request to clear the write-enable latch |
| busy | output | 1 | Program in progress |
| prog_req | output | 1 | One-cycle program request |
| prog_addr | output | 24 | Start address of the committed frame |
| prog_strb | output | 256 | Page offsets written by the committed frame |
| rd_addr | input | MEM_W | Memory model read address |
| rd_data | output | 8 | Memory model read data |

## Verification
A two-byte program into an erased page confirms the code match, the group order and the address capture. Reprogramming the same location shows an AND rather than an overwrite. A three-byte frame that starts two bytes before the end of a page separates wrapping from carrying into the next page. A frame of 257 bytes shows whether a repeated offset keeps its last byte. Frames with a wrong code, with wel low, with only an address or with a trailing half byte each must leave the memory erased and raise no request. A second frame started inside the busy window shows whether frames are rejected during a program.

// File: rtl/qpp_rx.sv
module qpp_rx #(
  parameter int          MEM_W       = 10,
  parameter int          PAGE_W      = 8,
  parameter int          PROG_CYCLES = 200,
  parameter logic [7:0]  OPCODE      = 8'h38
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cs_n,
  input  logic                      sclk,
  input  logic [3:0]                sio,
  input  logic                      wel,
  output logic                      wel_clr,
  output logic                      busy,
  output logic                      prog_req,
  output logic [23:0]               prog_addr,
  output logic [(1<<PAGE_W)-1:0]    prog_strb,
  input  logic [MEM_W-1:0]          rd_addr,
  output logic [7:0]                rd_data
);
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int MEM_BYTES  = 1 << MEM_W;
  localparam int CNT_W      = $clog2(PROG_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_OPC, S_ADDR, S_DATA, S_SKIP} st_t;

  st_t                   st;
  logic                  cs_r, cs_q, sclk_r, sclk_q;
  logic [3:0]            sio_r;
  logic [7:0]            opc;
  logic [23:0]           addr;
  logic [2:0]            cnt;
  logic                  half, got;
  logic [3:0]            hi;
  logic [PAGE_W-1:0]     ptr;
  logic [PAGE_BYTES-1:0] strb_buf;
  logic [7:0]            pbuf [PAGE_BYTES];
  logic [7:0]            mem  [MEM_BYTES];
  logic [CNT_W-1:0]      bcnt;

  wire sck_rise  = sclk_r & ~sclk_q & ~cs_r;
  wire cs_fall   = cs_q & ~cs_r;
  wire cs_rise   = ~cs_q & cs_r;
  wire [7:0] opc_next = {opc[6:0], sio_r[0]};
  wire byte_done = sck_rise && !cs_fall && !cs_rise && st == S_DATA && half;
  wire commit    = cs_rise && st == S_DATA && !half && got && wel;
  wire finish    = busy && bcnt == '0;

  assign rd_data = mem[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_r <= 1'b1; cs_q <= 1'b1; sclk_r <= 1'b0; sclk_q <= 1'b0; sio_r <= '0;
    end else begin
      cs_r <= cs_n; cs_q <= cs_r; sclk_r <= sclk; sclk_q <= sclk_r; sio_r <= sio;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; opc <= '0; addr <= '0; cnt <= '0; half <= 1'b0; got <= 1'b0;
      hi <= '0; ptr <= '0; strb_buf <= '0;
      prog_req <= 1'b0; prog_addr <= '0; prog_strb <= '0;
    end else begin
      prog_req <= 1'b0;
      if (cs_fall) begin
        st <= busy ? S_SKIP : S_OPC;
        cnt <= '0; half <= 1'b0; got <= 1'b0; strb_buf <= '0;
      end else if (cs_rise) begin
        if (commit) begin
          prog_req  <= 1'b1;
          prog_addr <= addr;
          prog_strb <= strb_buf;
        end
        st <= S_IDLE;
      end else if (sck_rise) begin
        case (st)
          S_OPC: begin
            opc <= opc_next;
            cnt <= cnt + 3'd1;
            if (cnt == 3'd7) begin
              st  <= (opc_next == OPCODE) ? S_ADDR : S_SKIP;
              cnt <= '0;
            end
          end
          S_ADDR: begin
            addr <= {addr[19:0], sio_r};
            cnt  <= cnt + 3'd1;
            if (cnt == 3'd5) begin
              st  <= S_DATA;
              ptr <= PAGE_W'({addr[3:0], sio_r});
            end
          end
          S_DATA: begin
            if (!half) begin
              hi   <= sio_r;
              half <= 1'b1;
            end else begin
              strb_buf[ptr] <= 1'b1;
              ptr  <= ptr + 1'b1;
              half <= 1'b0;
              got  <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (byte_done) pbuf[ptr] <= {hi, sio_r};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; bcnt <= '0; wel_clr <= 1'b0;
    end else begin
      wel_clr <= 1'b0;
      if (prog_req) begin
        busy <= 1'b1;
        bcnt <= CNT_W'(PROG_CYCLES - 1);
      end else if (busy) begin
        if (finish) begin
          busy    <= 1'b0;
          wel_clr <= 1'b1;
        end else begin
          bcnt <= bcnt - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < MEM_BYTES; j++) mem[j] <= 8'hFF;
    end else if (finish) begin
      for (int i = 0; i < PAGE_BYTES; i++)
        if (prog_strb[i])
          mem[{prog_addr[MEM_W-1:PAGE_W], PAGE_W'(i)}] <=
            mem[{prog_addr[MEM_W-1:PAGE_W], PAGE_W'(i)}] & pbuf[i];
    end
  end
endmodule

module qpp_rx_chk #(
  parameter int PROG_CYCLES = 200,
  parameter int PAGE_BYTES  = 256
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  wel,
  input logic                  wel_clr,
  input logic                  busy,
  input logic                  prog_req,
  input logic [PAGE_BYTES-1:0] prog_strb
);
  int run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run <= 0;
    else if (busy) run <= run + 1;
    else run <= 0;
  end

  AST_REQ_PULSE:      assert property (@(posedge clk) disable iff (!rst_n) prog_req |=> !prog_req);      // R8
  AST_REQ_HAS_BYTE:   assert property (@(posedge clk) disable iff (!rst_n) prog_req |-> |prog_strb);     // R7
  AST_REQ_NEEDS_WEL:  assert property (@(posedge clk) disable iff (!rst_n) prog_req |-> $past(wel));     // R6
  AST_BUSY_FOLLOWS:   assert property (@(posedge clk) disable iff (!rst_n) prog_req |=> busy);           // R9
  AST_NO_REQ_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n) prog_req |-> !busy);          // R10
  AST_CLR_ON_DONE:    assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> wel_clr);     // R9
  AST_CLR_PULSE:      assert property (@(posedge clk) disable iff (!rst_n) wel_clr |=> !wel_clr);        // R9
  AST_BUSY_LENGTH:    assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> run == PROG_CYCLES); // R9
endmodule

bind qpp_rx qpp_rx_chk #(.PROG_CYCLES(PROG_CYCLES), .PAGE_BYTES(1 << PAGE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wel(wel), .wel_clr(wel_clr), .busy(busy),
  .prog_req(prog_req), .prog_strb(prog_strb)
);

// File: tb/qpp_rx_test.sv
module qpp_rx_test;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_W = 10;
  localparam int PROG  = 200;
  localparam logic [7:0] OPC = 8'h38;

  logic clk = 0, rst_n = 0, cs_n = 1, sclk = 0, wel = 0;
  logic [3:0] sio = 0;
  logic wel_clr, busy, prog_req;
  logic [23:0] prog_addr;
  logic [255:0] prog_strb;
  logic [MEM_W-1:0] rd_addr = 0;
  logic [7:0] rd_data;

  int checks = 0, errors = 0;
  int req_n = 0, clr_n = 0, run = 0, last_run = 0;
  logic [23:0] last_addr;
  logic [255:0] last_strb;
  logic [7:0] dbuf [0:299];
  logic [7:0] v;

  qpp_rx #(.MEM_W(MEM_W), .PAGE_W(8), .PROG_CYCLES(PROG), .OPCODE(OPC)) uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sio(sio), .wel(wel),
    .wel_clr(wel_clr), .busy(busy), .prog_req(prog_req), .prog_addr(prog_addr),
    .prog_strb(prog_strb), .rd_addr(rd_addr), .rd_data(rd_data));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (prog_req) begin req_n++; last_addr = prog_addr; last_strb = prog_strb; end
    if (wel_clr) clr_n++;
    if (busy) run++;
    else if (run != 0) begin last_run = run; run = 0; end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    rd_addr = MEM_W'(a);
    #1 d = rd_data;
  endtask

  task automatic tick();
    repeat (2) @(negedge clk); sclk = 1;
    repeat (2) @(negedge clk); sclk = 0;
  endtask

  task automatic frame(input logic [7:0] op, input logic [23:0] a, input int n, input bit extra);
    cs_n = 0;
    repeat (2) @(negedge clk);
    for (int i = 7; i >= 0; i--) begin sio = {3'b0, op[i]}; tick(); end
    for (int k = 5; k >= 0; k--) begin sio = a[4*k +: 4]; tick(); end
    for (int b = 0; b < n; b++) begin
      sio = dbuf[b][7:4]; tick();
      sio = dbuf[b][3:0]; tick();
    end
    if (extra) begin sio = 4'hA; tick(); end
    repeat (2) @(negedge clk);
    cs_n = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic settle();
    repeat (PROG + 20) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0);
    chk("R1 prog_req", prog_req, 0);
    chk("R1 wel_clr", wel_clr, 0);
    rd(0, v); chk("R1 mem[0]", v, 8'hFF);
    rd(1023, v); chk("R1 mem[last]", v, 8'hFF);
  endtask

  task automatic t_basic();
    int r0 = req_n, c0 = clr_n;
    wel = 1; dbuf[0] = 8'hA5; dbuf[1] = 8'h3C;
    frame(OPC, 24'h000110, 2, 0);
    settle();
    chk("R8 req count", req_n - r0, 1);
    chk("R8 prog_addr", last_addr, 24'h000110);
    chk("R8 strb bits", {31'b0, last_strb[8'h10] & last_strb[8'h11]}, 1);
    chk("R8 strb count", $countones(last_strb), 2);
    chk("R9 busy length", last_run, PROG);
    chk("R9 wel_clr count", clr_n - c0, 1);
    rd(12'h110, v); chk("R3 first byte", v, 8'hA5);
    rd(12'h111, v); chk("R3 second byte", v, 8'h3C);
    rd(12'h112, v); chk("R3 untouched", v, 8'hFF);
  endtask

  task automatic t_and();
    dbuf[0] = 8'h0F;
    frame(OPC, 24'h000110, 1, 0);
    settle();
    rd(12'h110, v); chk("R4 and merge", v, 8'h05);
  endtask

  task automatic t_wrap();
    dbuf[0] = 8'h11; dbuf[1] = 8'h22; dbuf[2] = 8'h33;
    frame(OPC, 24'h0002FE, 3, 0);
    settle();
    rd(12'h2FE, v); chk("R5 offset FE", v, 8'h11);
    rd(12'h2FF, v); chk("R5 offset FF", v, 8'h22);
    rd(12'h200, v); chk("R5 wrapped to 00", v, 8'h33);
    rd(12'h300, v); chk("R5 next page untouched", v, 8'hFF);
  endtask

  task automatic t_nowel();
    int r0 = req_n, c0 = clr_n;
    wel = 0; dbuf[0] = 8'h00;
    frame(OPC, 24'h000050, 1, 0);
    settle();
    wel = 1;
    chk("R6 no request", req_n - r0, 0);
    chk("R6 no wel_clr", clr_n - c0, 0);
    rd(12'h050, v); chk("R6 memory kept", v, 8'hFF);
  endtask

  task automatic t_partial();
    int r0 = req_n;
    dbuf[0] = 8'h00;
    frame(OPC, 24'h000060, 1, 1);
    settle();
    frame(OPC, 24'h000061, 0, 0);
    settle();
    chk("R7 no request", req_n - r0, 0);
    rd(12'h060, v); chk("R7 half byte discarded", v, 8'hFF);
    rd(12'h061, v); chk("R7 address only discarded", v, 8'hFF);
  endtask

  task automatic t_badop();
    int r0 = req_n;
    dbuf[0] = 8'h00;
    frame(8'h02, 24'h000070, 1, 0);
    settle();
    chk("R2 wrong code no request", req_n - r0, 0);
    rd(12'h070, v); chk("R2 wrong code memory kept", v, 8'hFF);
  endtask

  task automatic t_busy();
    int r0 = req_n;
    dbuf[0] = 8'h5A;
    frame(OPC, 24'h000080, 1, 0);
    chk("R10 busy after commit", busy, 1);
    dbuf[0] = 8'h00;
    frame(OPC, 24'h000081, 1, 0);
    settle();
    chk("R10 single request", req_n - r0, 1);
    rd(12'h080, v); chk("R10 first frame programmed", v, 8'h5A);
    rd(12'h081, v); chk("R10 second frame ignored", v, 8'hFF);
  endtask

  task automatic t_repeat();
    dbuf[0] = 8'h00;
    for (int b = 1; b < 256; b++) dbuf[b] = 8'hFF;
    dbuf[256] = 8'h7E;
    frame(OPC, 24'h0003F0, 257, 0);
    settle();
    rd(12'h3F0, v); chk("R11 last write wins", v, 8'h7E);
    chk("R8 full page strobes", $countones(last_strb), 256);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        repeat (2) @(negedge clk);
        t_reset();
        t_basic();
        t_and();
        t_wrap();
        t_nowel();
        t_partial();
        t_badop();
        t_busy();
        t_repeat();
      end
      begin
        repeat (150000) @(negedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule